// File: doc/BRIEF.md
# Serial Rate-Half Convolutional Encoder

This block encodes a stream of information bits with a rate 1/2 convolutional code of constraint length 7. Each accepted bit is combined with the six bits held in a delay line to form two parity symbols. The second parity symbol is complemented. Both symbols leave on one serial line, the first parity symbol before the second, so every input bit costs two output beats.

Bits enter through a valid/ready handshake, and symbols leave through a second valid/ready handshake. A new bit is taken only when no pair is being presented, or when the second symbol of the current pair is leaving in that same cycle. This gives back-to-back throughput with no storage beyond one symbol pair. A flush request makes the encoder feed six zero bits into the code. Its state then returns to all zeros, and the next bit is encoded as if the block had just left reset.

Top module: `conv_enc_serial`

## Requirements
- R1: After a synchronous reset, out_valid and sym_is_c2 are 0, in_ready is 1 while flush is low, and all six delay stages hold zero.
- R2: The first symbol of each pair is the XOR of the window bits selected by 1111001. The leftmost bit selects the newest (current) input bit and the rightmost bit selects the oldest delay stage.
- R3: The second symbol of each pair is the complement of the XOR of the window bits selected by 1011011, using the same bit order as R2.
- R4: Each pair is sent first-symbol first. sym_is_c2 is 0 while the first symbol is presented and 1 while the second is presented.
- R5: Every accepted bit produces exactly two output beats. out_valid is high whenever accepted symbols remain undelivered, except in the cycle just after a flush is taken.
- R6: in_ready is high only when no symbol is presented, or when the second symbol is presented with out_ready high.
- R7: While out_valid is high and out_ready is low, out_sym and sym_is_c2 hold their values and nothing is lost or repeated.
- R8: A flush feeds six zero bits into the code and yields twelve symbols after any pair already pending. in_ready stays low until the last tail bit has entered the delay line. The delay line then holds all zeros.
- R9: In any cycle where flush is high, in_ready is low and no input bit is taken. A flush raised while a tail is still being inserted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit offered |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Encoder takes the bit this cycle |
| flush | input | 1 | Request to insert the six-bit zero tail |
| out_valid | output | 1 | A symbol is presented |
| out_sym | output | 1 | Serial code symbol |
| sym_is_c2 | output | 1 | Presented symbol is the second of its pair |
| out_ready | input | 1 | Consumer takes the symbol this cycle |

## Verification
The hardest situation to reach from the ports is a new bit entering at the same edge where the second symbol of the previous pair leaves while the consumer is throttling. The order of the delay-line shift and the selector reset matters only there. Random stimulus drives out_ready and in_valid independently every cycle with a fixed seed, so this overlap occurs many times, mixed with stalls on either symbol. Flush requests are also dropped in while pairs are still pending. A directed impulse after reset and after a flush fixes the two generator sequences.

// File: rtl/conv_enc_serial.sv
module conv_enc_serial #(
  parameter int K = 7,
  parameter logic [K-1:0] GEN_A = 7'b1111001,
  parameter logic [K-1:0] GEN_B = 7'b1011011,
  parameter bit INV_B = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  input  logic flush,
  output logic out_valid,
  output logic out_sym,
  output logic sym_is_c2,
  input  logic out_ready
);
  localparam int M  = K - 1;
  localparam int TW = $clog2(K);

  logic [M-1:0]  dl;
  logic [TW-1:0] tail_cnt;
  logic          busy, phase, sym_a, sym_b;

  wire          tailing  = tail_cnt != '0;
  wire          can_load = !busy || (phase && out_ready);
  wire          load     = can_load && (tailing || (in_valid && !flush));
  wire          new_bit  = tailing ? 1'b0 : in_bit;
  wire  [K-1:0] win      = {new_bit, dl};

  assign in_ready  = can_load && !tailing && !flush;
  assign out_valid = busy;
  assign sym_is_c2 = phase;
  assign out_sym   = phase ? sym_b : sym_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      dl    <= '0;
      busy  <= 1'b0;
      phase <= 1'b0;
      sym_a <= 1'b0;
      sym_b <= 1'b0;
    end else if (load) begin
      dl    <= win[K-1:1];
      sym_a <= ^(win & GEN_A);
      sym_b <= (^(win & GEN_B)) ^ INV_B;
      busy  <= 1'b1;
      phase <= 1'b0;
    end else if (busy && out_ready) begin
      busy  <= !phase;
      phase <= !phase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  tail_cnt <= '0;
    else if (flush && !tailing) tail_cnt <= TW'(M);
    else if (load && tailing)   tail_cnt <= tail_cnt - 1'b1;
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sym) && $stable(sym_is_c2));

  // R4
  c1_then_c2_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !sym_is_c2 |=> out_valid && sym_is_c2);

  // R5
  pair_start_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && !sym_is_c2);

  // R6
  accept_gate_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |-> !out_valid || (sym_is_c2 && out_ready));

  // R8
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tailing) |-> dl == '0);
endmodule

// File: tb/tb_conv_enc_serial.sv
module tb_conv_enc_serial;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_bit = 0, flush = 0, out_ready = 0;
  logic in_ready, out_valid, out_sym, sym_is_c2;
  int errors = 0, checks = 0;
  bit q[$];
  int tail_left = 0;
  logic [6:1] h = '0;
  logic prev_stall = 0, prev_sym = 0;

  always #10 clk = ~clk;

  conv_enc_serial dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .flush(flush), .out_valid(out_valid), .out_sym(out_sym),
    .sym_is_c2(sym_is_c2), .out_ready(out_ready));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_bit(input logic b);
    logic c1, c2;
    c1 = b ^ h[1] ^ h[2] ^ h[3] ^ h[6];
    c2 = ~(b ^ h[2] ^ h[3] ^ h[5] ^ h[6]);
    h = {h[5:1], b};
    q.push_back(c1);
    q.push_back(c2);
  endtask

  task automatic step(input logic iv, input logic ib, input logic ordy, input logic fl);
    logic exp_ir, odd;
    @(negedge clk);
    in_valid = iv; in_bit = ib; out_ready = ordy; flush = fl;
    #1;
    odd = (q.size() % 2) == 1;
    exp_ir = !fl && tail_left <= 2 && (q.size() == 0 || (odd && ordy));
    chk(fl ? "R9" : (tail_left > 2 ? "R8" : "R6"), in_ready, exp_ir);
    if (tail_left != 12) begin
      chk("R5", out_valid, q.size() != 0);
      if (out_valid) chk("R4", sym_is_c2, odd);
    end
    if (prev_stall) chk("R7", out_sym, prev_sym);
    prev_stall = out_valid && !ordy;
    prev_sym = out_sym;
    if (out_valid && ordy) begin
      if (q.size() == 0) chk("R5", out_valid, 1'b0);
      else begin
        chk(sym_is_c2 ? "R3" : "R2", out_sym, q[0]);
        if (q.size() <= tail_left) tail_left--;
        void'(q.pop_front());
      end
    end
    if (iv && in_ready) push_bit(ib);
    if (fl && tail_left == 0) begin
      for (int i = 0; i < 6; i++) push_bit(1'b0);
      tail_left = 12;
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((q.size() != 0 || out_valid) && n < 200) begin
      step(1'b0, 1'b0, 1'b1, 1'b0);
      n++;
    end
    step(1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", out_valid, 1'b0);
    chk("R1", sym_is_c2, 1'b0);
    chk("R1", in_ready, 1'b1);
    // R1 R2 R3: impulse from zero state
    step(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    drain();
    // R7: stall on both symbols
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    drain();
    // R8 R9: flush with a pending pair, flush ignored while tailing, then impulse
    step(1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b1, 1'b0);
    drain();
    step(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b1, 1'b0);
    drain();
    // random traffic with backpressure and flushes
    for (int i = 0; i < 20000; i++) begin
      logic fl;
      fl = tail_left == 0 && ($urandom % 64) == 0;
      step(($urandom % 4) != 0, $urandom % 2, ($urandom % 3) != 0, fl);
    end
    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule